// File: doc/BRIEF.md
# Programmable Video Sync Generator

This block frames a parallel pixel bus with horizontal and vertical sync strobes. It keeps its own column and row counters, runs on a free-running pixel clock, and registers every output on the rising edge. The configuration sets the number of active columns per row and active rows per frame. A fixed horizontal blanking tail follows each row and a fixed vertical blanking tail follows each frame. Pixel words presented on the input are passed to the bus during the active area and replaced by zero elsewhere.

Each sync output runs in one of two modes, chosen by its own mode bit. In level mode the strobe spans the active pixels. In pulse mode the strobe is issued once the row or frame has ended. Each output also has its own polarity bit and two signed offsets that move its asserting and deasserting edges. Hsync offsets count pixel clocks and vsync offsets count rows. The whole configuration is captured at frame boundaries only.

Top module: `vid_sync_gen`

## Requirements
- R1: Mode bit 0 selects level mode and mode bit 1 selects pulse mode. Hsync and vsync each have their own mode bit and their own polarity bit.
- R2: In level mode with zero offsets, hsync is active from column 0 to column A-1 of every active row, where A is the active column count. Its leading edge appears on the same clock as the row's first pixel on the bus.
- R3: In level mode with zero offsets, vsync turns active with the first pixel of row 0. It turns inactive on the clock after the last pixel of row R-1 leaves the bus, where R is the active row count.
- R4: In pulse mode with zero offsets, hsync is active for 4 clocks starting at column A of each active row. Vsync is active for the whole of row R, the first blanking row.
- R5: When a polarity bit is 1 the output is high while active. When it is 0 the output is low while active. After reset the defaults are hsync active high and vsync active low.
- R6: The signed start offset is added to the default asserting position and the signed end offset is added to the default deasserting position. Both count pixel clocks for hsync and rows for vsync. The start position is clamped to the row or frame, and the end position is clamped to at least start plus the minimum width and at most the row or frame length.
- R7: At a position inside the active area, data_o carries the pixel word that was on pix_data_i just before the clock that presents that position. Everywhere else data_o is zero.
- R8: All configuration inputs are sampled only at the first clock after reset and at each frame wrap. A change made in the middle of a frame has no effect until the next frame.
- R9: An active-low reset forces hsync low, vsync high and data zero at once. Counting restarts at column 0 of row 0, and the first position is presented on the second clock edge after release.
- R10: A row lasts A+H_BLANK clocks and a frame lasts R+V_BLANK rows. An active count of zero is treated as one.
- R11: An hsync pulse in pulse mode lasts at least 4 clocks whatever the offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_cols_i | input | COL_W | Active columns per row |
| act_rows_i | input | ROW_W | Active rows per frame |
| hs_mode_i | input | 1 | Hsync mode: 0 level, 1 pulse |
| vs_mode_i | input | 1 | Vsync mode: 0 level, 1 pulse |
| hs_pol_i | input | 1 | Hsync active level |
| vs_pol_i | input | 1 | Vsync active level |
| hs_start_off_i | input | OFF_W | Signed hsync leading-edge shift, in clocks |
| hs_end_off_i | input | OFF_W | Signed hsync trailing-edge shift, in clocks |
| vs_start_off_i | input | OFF_W | Signed vsync leading-edge shift, in rows |
| vs_end_off_i | input | OFF_W | Signed vsync trailing-edge shift, in rows |
| pix_data_i | input | DATA_W | Pixel word to place on the bus |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| data_o | output | DATA_W | Pixel bus, zero outside the active area |

## Verification
A column or row counter that has slipped moves every hsync edge and every data window within one row, so a full-frame compare against a position model exposes it in a few dozen clocks. Bounds captured at the wrong moment, or a stale shadow register, appear as a wrongly sized strobe in the frame after a mid-frame configuration change. A wrong clamp appears as a pulse shorter than four clocks, or as an inverted window, in the first affected row. Polarity and reset faults are visible on the very next edge, or immediately when reset is asserted.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  typedef enum logic {
    SYNC_LEVEL = 1'b0,
    SYNC_PULSE = 1'b1
  } sync_mode_e;

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/vsg_bounds.sv
// Window [start, end) along one axis, mode folded into the bounds.
module vsg_bounds #(
  parameter int POS_W    = 9,
  parameter int OFF_W    = 5,
  parameter int PULSE_MIN = 4
) (
  input  logic                    mode_i,
  input  logic [POS_W-1:0]        act_len_i,
  input  logic [POS_W-1:0]        tot_len_i,
  input  logic signed [OFF_W-1:0] off_s_i,
  input  logic signed [OFF_W-1:0] off_e_i,
  output logic [POS_W-1:0]        start_o,
  output logic [POS_W-1:0]        end_o
);
  import vsg_pkg::*;

  int act_l, tot_l, min_w, base_s, base_e, s_l, e_l;

  always_comb begin
    act_l  = int'(act_len_i);
    tot_l  = int'(tot_len_i);
    min_w  = (mode_i == SYNC_PULSE) ? PULSE_MIN : 1;
    base_s = (mode_i == SYNC_PULSE) ? act_l : 0;
    base_e = (mode_i == SYNC_PULSE) ? act_l + PULSE_MIN : act_l;
    s_l    = clamp_int(base_s + int'(off_s_i), 0, tot_l - min_w);
    e_l    = clamp_int(base_e + int'(off_e_i), s_l + min_w, tot_l);
    start_o = POS_W'(s_l);
    end_o   = POS_W'(e_l);
  end

endmodule

// File: rtl/vsg_timebase.sv
module vsg_timebase #(
  parameter int CPOS_W = 9,
  parameter int RPOS_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CPOS_W-1:0] tot_cols_i,
  input  logic [RPOS_W-1:0] tot_rows_i,
  output logic [CPOS_W-1:0] col_o,
  output logic [RPOS_W-1:0] row_o,
  output logic              started_o,
  output logic              load_o
);
  logic [CPOS_W-1:0] col_q;
  logic [RPOS_W-1:0] row_q;
  logic              started_q;
  logic              col_last, row_last;

  assign col_last = (col_q == tot_cols_i - CPOS_W'(1));
  assign row_last = (row_q == tot_rows_i - RPOS_W'(1));
  assign load_o   = !started_q || (col_last && row_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q     <= '0;
      row_q     <= '0;
      started_q <= 1'b0;
    end else if (!started_q) begin
      started_q <= 1'b1;
    end else if (col_last) begin
      col_q <= '0;
      row_q <= row_last ? '0 : row_q + RPOS_W'(1);
    end else begin
      col_q <= col_q + CPOS_W'(1);
    end
  end

  assign col_o     = col_q;
  assign row_o     = row_q;
  assign started_o = started_q;

endmodule

// File: rtl/vsg_sync_reg.sv
module vsg_sync_reg #(
  parameter logic RST_PIN = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic started_i,
  input  logic on_i,
  input  logic pol_i,
  output logic on_o,
  output logic pin_o
);
  logic on_g;
  assign on_g = started_i & on_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_o  <= 1'b0;
      pin_o <= RST_PIN;
    end else begin
      on_o  <= on_g;
      pin_o <= ~(on_g ^ pol_i);
    end
  end

endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen #(
  parameter int DATA_W       = 10,
  parameter int COL_W        = 8,
  parameter int ROW_W        = 8,
  parameter int OFF_W        = 5,
  parameter int H_BLANK      = 6,
  parameter int V_BLANK      = 2,
  parameter int HS_PULSE_MIN = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [COL_W-1:0]        act_cols_i,
  input  logic [ROW_W-1:0]        act_rows_i,
  input  logic                    hs_mode_i,
  input  logic                    vs_mode_i,
  input  logic                    hs_pol_i,
  input  logic                    vs_pol_i,
  input  logic signed [OFF_W-1:0] hs_start_off_i,
  input  logic signed [OFF_W-1:0] hs_end_off_i,
  input  logic signed [OFF_W-1:0] vs_start_off_i,
  input  logic signed [OFF_W-1:0] vs_end_off_i,
  input  logic [DATA_W-1:0]       pix_data_i,
  output logic                    hsync_o,
  output logic                    vsync_o,
  output logic [DATA_W-1:0]       data_o
);
  import vsg_pkg::*;

  localparam int CPOS_W = COL_W + 1;
  localparam int RPOS_W = ROW_W + 1;
  localparam logic HS_POL_RST = 1'b1;
  localparam logic VS_POL_RST = 1'b0;

  // raw config, normalised
  logic [CPOS_W-1:0] a_cols_d, tot_cols_d, hs_s_d, hs_e_d;
  logic [RPOS_W-1:0] a_rows_d, tot_rows_d, vs_s_d, vs_e_d;

  assign a_cols_d   = (act_cols_i == '0) ? CPOS_W'(1) : {1'b0, act_cols_i};
  assign a_rows_d   = (act_rows_i == '0) ? RPOS_W'(1) : {1'b0, act_rows_i};
  assign tot_cols_d = a_cols_d + CPOS_W'(H_BLANK);
  assign tot_rows_d = a_rows_d + RPOS_W'(V_BLANK);

  vsg_bounds #(.POS_W(CPOS_W), .OFF_W(OFF_W), .PULSE_MIN(HS_PULSE_MIN)) hs_bounds_i (
    .mode_i   (hs_mode_i),
    .act_len_i(a_cols_d),
    .tot_len_i(tot_cols_d),
    .off_s_i  (hs_start_off_i),
    .off_e_i  (hs_end_off_i),
    .start_o  (hs_s_d),
    .end_o    (hs_e_d)
  );

  // one full row already exceeds the pulse minimum
  vsg_bounds #(.POS_W(RPOS_W), .OFF_W(OFF_W), .PULSE_MIN(1)) vs_bounds_i (
    .mode_i   (vs_mode_i),
    .act_len_i(a_rows_d),
    .tot_len_i(tot_rows_d),
    .off_s_i  (vs_start_off_i),
    .off_e_i  (vs_end_off_i),
    .start_o  (vs_s_d),
    .end_o    (vs_e_d)
  );

  // frame shadow
  logic [CPOS_W-1:0] a_cols_q, tot_cols_q, hs_s_q, hs_e_q;
  logic [RPOS_W-1:0] a_rows_q, tot_rows_q, vs_s_q, vs_e_q;
  logic              hs_mode_q, vs_mode_q, hs_pol_q, vs_pol_q;
  logic              load, started_q;
  logic [CPOS_W-1:0] col_q;
  logic [RPOS_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_cols_q   <= CPOS_W'(1);
      a_rows_q   <= RPOS_W'(1);
      tot_cols_q <= CPOS_W'(1 + H_BLANK);
      tot_rows_q <= RPOS_W'(1 + V_BLANK);
      hs_s_q     <= '0;
      hs_e_q     <= CPOS_W'(1);
      vs_s_q     <= '0;
      vs_e_q     <= RPOS_W'(1);
      hs_mode_q  <= SYNC_LEVEL;
      vs_mode_q  <= SYNC_LEVEL;
      hs_pol_q   <= HS_POL_RST;
      vs_pol_q   <= VS_POL_RST;
    end else if (load) begin
      a_cols_q   <= a_cols_d;
      a_rows_q   <= a_rows_d;
      tot_cols_q <= tot_cols_d;
      tot_rows_q <= tot_rows_d;
      hs_s_q     <= hs_s_d;
      hs_e_q     <= hs_e_d;
      vs_s_q     <= vs_s_d;
      vs_e_q     <= vs_e_d;
      hs_mode_q  <= hs_mode_i;
      vs_mode_q  <= vs_mode_i;
      hs_pol_q   <= hs_pol_i;
      vs_pol_q   <= vs_pol_i;
    end
  end

  vsg_timebase #(.CPOS_W(CPOS_W), .RPOS_W(RPOS_W)) tb_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tot_cols_i(tot_cols_q),
    .tot_rows_i(tot_rows_q),
    .col_o     (col_q),
    .row_o     (row_q),
    .started_o (started_q),
    .load_o    (load)
  );

  // window decode
  logic in_rows, in_cols, hs_on_d, vs_on_d, vs_last_row;

  assign in_rows     = (row_q < a_rows_q);
  assign in_cols     = (col_q < a_cols_q);
  assign vs_last_row = (row_q == vs_e_q - RPOS_W'(1));
  assign hs_on_d     = in_rows && (col_q >= hs_s_q) && (col_q < hs_e_q);

  always_comb begin
    if (vs_mode_q == SYNC_PULSE)
      vs_on_d = (row_q >= vs_s_q) && (row_q < vs_e_q);
    else // level: release after last active pixel of closing row
      vs_on_d = ((row_q >= vs_s_q) && (row_q < vs_e_q - RPOS_W'(1))) ||
                (vs_last_row && in_cols);
  end

  logic hs_on_q, vs_on_q;

  vsg_sync_reg #(.RST_PIN(~HS_POL_RST)) hs_reg_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .started_i(started_q),
    .on_i     (hs_on_d),
    .pol_i    (hs_pol_q),
    .on_o     (hs_on_q),
    .pin_o    (hsync_o)
  );

  vsg_sync_reg #(.RST_PIN(~VS_POL_RST)) vs_reg_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .started_i(started_q),
    .on_i     (vs_on_d),
    .pol_i    (vs_pol_q),
    .on_o     (vs_on_q),
    .pin_o    (vsync_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      data_o <= '0;
    else
      data_o <= (started_q && in_rows && in_cols) ? pix_data_i : '0;
  end

endmodule

// File: rtl/vid_sync_gen_chk.sv
module vid_sync_gen_chk #(
  parameter int DATA_W  = 10,
  parameter int CPOS_W  = 9,
  parameter int RPOS_W  = 9,
  parameter int PULSE_MIN = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_o,
  input logic [CPOS_W-1:0] col_q,
  input logic [RPOS_W-1:0] row_q,
  input logic [CPOS_W-1:0] tot_cols_q,
  input logic [RPOS_W-1:0] tot_rows_q,
  input logic [CPOS_W-1:0] a_cols_q,
  input logic [RPOS_W-1:0] a_rows_q,
  input logic              started_q,
  input logic              load,
  input logic              hs_mode_q,
  input logic              vs_mode_q,
  input logic              hs_on_q,
  input logic              vs_on_q
);
  logic [CPOS_W+RPOS_W-1:0] hs_run_q, vs_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_run_q <= '0;
      vs_run_q <= '0;
    end else begin
      hs_run_q <= hs_on_q ? hs_run_q + 1'b1 : '0;
      vs_run_q <= vs_on_q ? vs_run_q + 1'b1 : '0;
    end
  end

  p_col_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q < tot_cols_q);

  p_row_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_q < tot_rows_q);

  p_data_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o != '0) |-> $past(started_q && (row_q < a_rows_q) && (col_q < a_cols_q)));

  p_shadow_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(a_cols_q) |-> $past(load));

  p_hs_pulse_min_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_mode_q && $past(hs_mode_q) && $past(hs_on_q) && !hs_on_q)
      |-> (hs_run_q >= (CPOS_W+RPOS_W)'(PULSE_MIN)));

  p_vs_pulse_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_mode_q && $past(vs_mode_q) && $past(vs_on_q) && !vs_on_q)
      |-> (vs_run_q >= (CPOS_W+RPOS_W)'(PULSE_MIN)));

endmodule

bind vid_sync_gen vid_sync_gen_chk #(
  .DATA_W(DATA_W), .CPOS_W(CPOS_W), .RPOS_W(RPOS_W), .PULSE_MIN(HS_PULSE_MIN)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_o    (data_o),
  .col_q     (col_q),
  .row_q     (row_q),
  .tot_cols_q(tot_cols_q),
  .tot_rows_q(tot_rows_q),
  .a_cols_q  (a_cols_q),
  .a_rows_q  (a_rows_q),
  .started_q (started_q),
  .load      (load),
  .hs_mode_q (hs_mode_q),
  .vs_mode_q (vs_mode_q),
  .hs_on_q   (hs_on_q),
  .vs_on_q   (vs_on_q)
);

// File: tb/vid_sync_gen_tb_top.sv
module vid_sync_gen_tb_top;

  localparam int HB = 6;
  localparam int VB = 2;

  typedef struct packed {
    int act; int rows;
    bit hm; bit vm; bit hp; bit vp;
    int hso; int heo; int vso; int veo;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5, 3, 1'b0, 1'b0, 1'b1, 1'b0,  0,  0,  0,  0},
    '{5, 3, 1'b1, 1'b1, 1'b1, 1'b0,  0,  0,  0,  0},
    '{4, 2, 1'b0, 1'b0, 1'b0, 1'b1,  0,  0,  0,  0},
    '{6, 3, 1'b0, 1'b0, 1'b1, 1'b0,  2, -1,  1, -1},
    '{6, 3, 1'b1, 1'b1, 1'b0, 1'b0, -2,  3, -1,  1},
    '{3, 2, 1'b1, 1'b0, 1'b1, 1'b0,  5, -9,  0,  0},
    '{0, 0, 1'b0, 1'b1, 1'b1, 1'b1,  0,  0,  0,  0},
    '{4, 2, 1'b0, 1'b0, 1'b1, 1'b0, -3,  6, -2,  3}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] act_cols, act_rows;
  logic hs_mode, vs_mode, hs_pol, vs_pol;
  logic signed [4:0] hs_so, hs_eo, vs_so, vs_eo;
  logic [9:0] pix;
  logic hsync, vsync;
  logic [9:0] data;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  vid_sync_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .act_cols_i(act_cols), .act_rows_i(act_rows),
    .hs_mode_i(hs_mode), .vs_mode_i(vs_mode),
    .hs_pol_i(hs_pol), .vs_pol_i(vs_pol),
    .hs_start_off_i(hs_so), .hs_end_off_i(hs_eo),
    .vs_start_off_i(vs_so), .vs_end_off_i(vs_eo),
    .pix_data_i(pix),
    .hsync_o(hsync), .vsync_o(vsync), .data_o(data)
  );

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic logic [9:0] pat(int k);
    return 10'((k * 37 + 11) & 1023);
  endfunction

  function automatic int eff(int n);
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int frame_len(vec_t c);
    return (eff(c.act) + HB) * (eff(c.rows) + VB);
  endfunction

  task automatic expect_at(input vec_t c, input int col, input int row,
                           output bit hs, output bit vs, output bit act);
    int a, r, t, tr, hpm, hs_s, hs_e, vs_s, vs_e;
    bit hon, von;
    a = eff(c.act); r = eff(c.rows); t = a + HB; tr = r + VB;
    hpm  = c.hm ? 4 : 1;
    hs_s = clampi((c.hm ? a : 0) + c.hso, 0, t - hpm);
    hs_e = clampi((c.hm ? a + 4 : a) + c.heo, hs_s + hpm, t);
    hon  = (row < r) && (col >= hs_s) && (col < hs_e);
    vs_s = clampi((c.vm ? r : 0) + c.vso, 0, tr - 1);
    vs_e = clampi((c.vm ? r + 1 : r) + c.veo, vs_s + 1, tr);
    if (c.vm) von = (row >= vs_s) && (row < vs_e);
    else von = ((row >= vs_s) && (row < vs_e - 1)) || ((row == vs_e - 1) && (col < a));
    hs  = hon ? c.hp : !c.hp;
    vs  = von ? c.vp : !c.vp;
    act = (row < r) && (col < a);
  endtask

  task automatic apply(input vec_t c);
    act_cols = 8'(c.act); act_rows = 8'(c.rows);
    hs_mode = c.hm; vs_mode = c.vm; hs_pol = c.hp; vs_pol = c.vp;
    hs_so = 5'(c.hso); hs_eo = 5'(c.heo); vs_so = 5'(c.vso); vs_eo = 5'(c.veo);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act_v, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act_v, exp_v);
    end
  endtask

  // c0 for frame 0, c1 applied at position chg_k and used from frame 1 on
  task automatic run_case(input vec_t c0, input vec_t c1, input int chg_k,
                          input string hs_tag, input string vs_tag, input string d_tag);
    int col, row, total, lim_c, lim_r;
    vec_t cur;
    bit ehs, evs, ea, hs_ok, vs_ok, d_ok;
    int hs_a, hs_e, vs_a, vs_e, d_a, d_e;
    logic [9:0] ed;
    col = 0; row = 0; cur = c0;
    total = frame_len(c0) + frame_len(c1);
    hs_ok = 1; vs_ok = 1; d_ok = 1;
    hs_a = 0; hs_e = 0; vs_a = 0; vs_e = 0; d_a = 0; d_e = 0;
    @(negedge clk); rst_ni = 1'b0; apply(c0); pix = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); @(negedge clk); pix = pat(0);
    for (int k = 0; k < total; k++) begin
      @(posedge clk); @(negedge clk);
      expect_at(cur, col, row, ehs, evs, ea);
      ed = ea ? pat(k) : 10'd0;
      if (hs_ok && hsync !== ehs) begin hs_ok = 0; hs_a = int'(hsync); hs_e = int'(ehs); end
      if (vs_ok && vsync !== evs) begin vs_ok = 0; vs_a = int'(vsync); vs_e = int'(evs); end
      if (d_ok && data !== ed) begin d_ok = 0; d_a = int'(data); d_e = int'(ed); end
      pix = pat(k + 1);
      if (k + 1 == chg_k) apply(c1);
      lim_c = eff(cur.act) + HB; lim_r = eff(cur.rows) + VB;
      col++;
      if (col == lim_c) begin
        col = 0; row++;
        if (row == lim_r) begin row = 0; cur = c1; end
      end
    end
    check(hs_ok, hs_tag, "hsync frame compare", hs_a, hs_e);
    check(vs_ok, vs_tag, "vsync frame compare", vs_a, vs_e);
    check(d_ok,  d_tag,  "data frame compare",  d_a,  d_e);
  endtask

  initial begin
    #2000000;
    n_errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    apply(VECS[0]); pix = 10'h155;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R9 / R5: outputs held in reset at default inactive levels
    check(hsync === 1'b0, "R9", "hsync in reset", int'(hsync), 0);
    check(vsync === 1'b1, "R5", "vsync in reset", int'(vsync), 1);
    check(data === 10'd0, "R9", "data in reset", int'(data), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      case (i)
        0: run_case(VECS[i], VECS[i], 1, "R2", "R3", "R7");
        1: run_case(VECS[i], VECS[i], 1, "R1/R4", "R4", "R7");
        2: run_case(VECS[i], VECS[i], 1, "R5", "R5", "R7");
        3: run_case(VECS[i], VECS[i], 1, "R6", "R6", "R7");
        4: run_case(VECS[i], VECS[i], 1, "R6", "R6", "R7");
        5: run_case(VECS[i], VECS[i], 1, "R11", "R3", "R7");
        6: run_case(VECS[i], VECS[i], 1, "R10", "R10", "R10");
        default: run_case(VECS[i], VECS[i], 1, "R6", "R6", "R7");
      endcase
    end

    // R8: mid-frame reconfiguration waits for the frame wrap
    run_case(VECS[2], VECS[4], 5, "R8", "R8", "R8");
    // R1: modes switch independently across a frame wrap
    run_case(VECS[0], VECS[5], 20, "R1", "R1", "R8");

    // R9: asynchronous reset mid-frame with inverted polarities
    @(negedge clk); rst_ni = 1'b0; apply(VECS[2]);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_ni = 1'b0;
    #1;
    check(hsync === 1'b0, "R9", "hsync at async reset", int'(hsync), 0);
    check(vsync === 1'b1, "R9", "vsync at async reset", int'(vsync), 1);
    check(data === 10'd0, "R9", "data at async reset", int'(data), 0);
    // restart from column 0 after reset
    run_case(VECS[0], VECS[0], 1, "R9", "R9", "R9");

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule